// File: doc/BRIEF.md
# Unary Dependency Matrix Scoreboard

This block tracks operand hazards for a small pool of function units in an out-of-order core. Every register reference is carried as a one-hot vector with one bit per architectural register, so each hazard test is one AND per bit followed by an OR reduction. There is no comparator on encoded register numbers. Two matrices hold the state. The first records, for each unit, which registers it will write and which it still has to read. The second records, for each pair of units, whether one must wait for the other before reading its operands, and whether one must wait for the other before writing its result.

An instruction is offered with a one-hot destination vector and up to two one-hot source vectors. A zero vector means the operand is absent. When the block accepts the instruction it allocates the lowest-numbered idle unit and records the new unit's dependencies against every unit already in flight. Each busy unit gets a read grant once its read-wait row is empty and a write grant once its write-wait row is empty. When a unit reports completion, its row and its column in both matrices are cleared at the next rising edge. That releases everything that was waiting on it. An instruction whose destination is already the target of a pending write is not renamed: it is held back until that writer completes.

Top module: `unary_scoreboard`

## Requirements
- R1: After reset no unit is busy, no read or write grant is raised, and issueReady is 1.
- R2: An issue is accepted when issueValid and issueReady are both 1. The accepted instruction goes to the lowest-numbered idle unit. issueGrant shows that unit one-hot in the same cycle, and the unit's busy bit is 1 from the next cycle.
- R3: issueReady is 0 whenever all units are busy.
- R4: issueReady is 0 whenever issueDest shares a bit with the destination of any busy unit, which is a write-after-write conflict.
- R5: A unit whose source vector shared a bit with the destination of a unit busy at issue keeps goRead at 0 until that unit has completed.
- R6: A unit whose destination shared a bit with a pending source of a unit busy at issue keeps goWrite at 0 until that unit has completed.
- R7: goRead and goWrite are 0 for idle units. For a busy unit each of them is 1 exactly when the matching wait row is empty.
- R8: When doneVec has a bit set for a busy unit, that unit is idle from the next cycle. Its destination no longer stalls issue, and no other unit still waits on it.
- R9: A doneVec bit for an idle unit changes nothing.
- R10: If an instruction issues in the same cycle as a unit it depends on completes, the new unit does not wait on that unit.
- R11: A refused or absent issue leaves the busy set and every grant unchanged when doneVec is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction is offered this cycle |
| issueDest | input | NUM_REG | One-hot destination register, or zero |
| issueSrcA | input | NUM_REG | One-hot first source register, or zero |
| issueSrcB | input | NUM_REG | One-hot second source register, or zero |
| issueReady | output | 1 | A unit is idle and no write-after-write conflict exists |
| issueGrant | output | NUM_FU | One-hot unit receiving the accepted instruction |
| doneVec | input | NUM_FU | Completion strobe per unit |
| busy | output | NUM_FU | Units holding an instruction |
| goRead | output | NUM_FU | Per-unit permission to read operands |
| goWrite | output | NUM_FU | Per-unit permission to write its result |

## Verification
The bound checker tests, on every cycle, the invariants that need no knowledge of register contents. issueGrant is one-hot and appears only when the block is ready. A full pool or a clashing destination refuses issue. Grants are never raised for idle units. An accepted issue adds exactly one busy unit, and completion frees the units that finished. The actual dependency links are only visible in the bench's scenarios, which a behavioural model compares on every clock. These cover read-after-write and write-after-read chains, release on completion, completion of an idle unit, and completion in the same cycle as a dependent issue.

// File: rtl/sb_pkg.sv
package sb_pkg;

  // strobes from control to the matrix datapath
  typedef struct packed {
    logic issueFire;  // instruction accepted this cycle
    logic clearAny;   // at least one busy unit completes
  } sbStrobe_t;

endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 8,
  parameter int NUM_REG = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [NUM_REG-1:0] issueDest,
  input  logic [NUM_REG-1:0] pendingWrites,
  input  logic [NUM_FU-1:0]  doneVec,
  output logic [NUM_FU-1:0]  busy,
  output logic               issueReady,
  output logic [NUM_FU-1:0]  allocMask,
  output logic [NUM_FU-1:0]  clearMask,
  output sbStrobe_t          strobe
);

  logic [NUM_FU-1:0] idleVec;
  logic [NUM_FU-1:0] lowestIdle;
  logic              anyIdle;
  logic              wawHit;
  logic              fire;

  assign idleVec    = ~busy;
  // isolate lowest set bit of the idle vector
  assign lowestIdle = idleVec & (~idleVec + NUM_FU'(1));
  assign anyIdle    = |idleVec;
  assign wawHit     = |(issueDest & pendingWrites);
  assign issueReady = anyIdle && !wawHit;
  assign fire       = issueValid && issueReady;

  assign allocMask  = fire ? lowestIdle : '0;
  assign clearMask  = doneVec & busy;

  assign strobe.issueFire = fire;
  assign strobe.clearAny  = |clearMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= '0;
    end else begin
      busy <= (busy | allocMask) & ~clearMask;
    end
  end

endmodule

// File: rtl/sb_matrix.sv
module sb_matrix
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 8,
  parameter int NUM_REG = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  sbStrobe_t          strobe,
  input  logic [NUM_FU-1:0]  allocMask,
  input  logic [NUM_FU-1:0]  clearMask,
  input  logic [NUM_FU-1:0]  busy,
  input  logic [NUM_REG-1:0] issueDest,
  input  logic [NUM_REG-1:0] issueSrcA,
  input  logic [NUM_REG-1:0] issueSrcB,
  output logic [NUM_REG-1:0] pendingWrites,
  output logic [NUM_FU-1:0]  goRead,
  output logic [NUM_FU-1:0]  goWrite
);

  // FU-Regs matrix: one row of register bits per unit
  logic [NUM_FU-1:0][NUM_REG-1:0] dstRow;
  logic [NUM_FU-1:0][NUM_REG-1:0] srcRow;
  // FU-FU matrix: row i, column j means unit i waits on unit j
  logic [NUM_FU-1:0][NUM_FU-1:0]  rdWait;
  logic [NUM_FU-1:0][NUM_FU-1:0]  wrWait;

  logic [NUM_REG-1:0] issueSrcAll;
  logic [NUM_FU-1:0]  rdHit;
  logic [NUM_FU-1:0]  wrHit;

  assign issueSrcAll = issueSrcA | issueSrcB;

  always_comb begin
    pendingWrites = '0;
    for (int j = 0; j < NUM_FU; j++) begin
      pendingWrites = pendingWrites | dstRow[j];
    end
  end

  genvar j, i;
  generate
    // column-wise hazard detection against the offered instruction
    for (j = 0; j < NUM_FU; j++) begin : g_col
      assign rdHit[j] = busy[j] & (|(issueSrcAll & dstRow[j]));
      assign wrHit[j] = busy[j] & (|(issueDest & srcRow[j]));
    end

    for (i = 0; i < NUM_FU; i++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rstN) begin
          dstRow[i] <= '0;
          srcRow[i] <= '0;
          rdWait[i] <= '0;
          wrWait[i] <= '0;
        end else if (clearMask[i]) begin
          dstRow[i] <= '0;
          srcRow[i] <= '0;
          rdWait[i] <= '0;
          wrWait[i] <= '0;
        end else if (strobe.issueFire && allocMask[i]) begin
          dstRow[i] <= issueDest;
          srcRow[i] <= issueSrcAll;
          rdWait[i] <= rdHit & ~clearMask;
          wrWait[i] <= wrHit & ~clearMask;
        end else if (strobe.clearAny) begin
          rdWait[i] <= rdWait[i] & ~clearMask;
          wrWait[i] <= wrWait[i] & ~clearMask;
        end
      end

      assign goRead[i]  = busy[i] & ~(|rdWait[i]);
      assign goWrite[i] = busy[i] & ~(|wrWait[i]);
    end
  endgenerate

endmodule

// File: rtl/unary_scoreboard.sv
module unary_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 8,
  parameter int NUM_REG = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [NUM_REG-1:0] issueDest,
  input  logic [NUM_REG-1:0] issueSrcA,
  input  logic [NUM_REG-1:0] issueSrcB,
  output logic               issueReady,
  output logic [NUM_FU-1:0]  issueGrant,
  input  logic [NUM_FU-1:0]  doneVec,
  output logic [NUM_FU-1:0]  busy,
  output logic [NUM_FU-1:0]  goRead,
  output logic [NUM_FU-1:0]  goWrite
);

  sbStrobe_t          strobe;
  logic [NUM_REG-1:0] pendingWrites;
  logic [NUM_FU-1:0]  allocMask;
  logic [NUM_FU-1:0]  clearMask;

  sb_ctrl #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .issueValid    (issueValid),
    .issueDest     (issueDest),
    .pendingWrites (pendingWrites),
    .doneVec       (doneVec),
    .busy          (busy),
    .issueReady    (issueReady),
    .allocMask     (allocMask),
    .clearMask     (clearMask),
    .strobe        (strobe)
  );

  sb_matrix #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_matrix (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .allocMask     (allocMask),
    .clearMask     (clearMask),
    .busy          (busy),
    .issueDest     (issueDest),
    .issueSrcA     (issueSrcA),
    .issueSrcB     (issueSrcB),
    .pendingWrites (pendingWrites),
    .goRead        (goRead),
    .goWrite       (goWrite)
  );

  assign issueGrant = allocMask;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int NUM_FU  = 8,
  parameter int NUM_REG = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [NUM_REG-1:0] issueDest,
  input logic               issueReady,
  input logic [NUM_FU-1:0]  issueGrant,
  input logic [NUM_FU-1:0]  doneVec,
  input logic [NUM_FU-1:0]  busy,
  input logic [NUM_FU-1:0]  goRead,
  input logic [NUM_FU-1:0]  goWrite,
  input logic [NUM_REG-1:0] pendingWrites
);

  logic fire;
  assign fire = issueValid && issueReady;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueGrant) && ((issueGrant != '0) == fire));

  assert_grant_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issueGrant & busy) == '0);

  assert_alloc_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (doneVec & busy) == '0) |=>
      $countones(busy) == $countones($past(busy)) + 1);

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (&busy) |-> !issueReady);

  assert_waw_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    fire |-> (issueDest & pendingWrites) == '0);

  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((goRead | goWrite) & ~busy) == '0);

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((doneVec & busy) != '0) |=> (busy & $past(doneVec & busy)) == '0);

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!fire && doneVec == '0) |=> $stable(busy));

endmodule

bind unary_scoreboard sb_checker #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .issueValid    (issueValid),
  .issueDest     (issueDest),
  .issueReady    (issueReady),
  .issueGrant    (issueGrant),
  .doneVec       (doneVec),
  .busy          (busy),
  .goRead        (goRead),
  .goWrite       (goWrite),
  .pendingWrites (pendingWrites)
);

// File: tb/sim_unary_scoreboard.sv
module sim_unary_scoreboard;

  localparam int NF = 8;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          issueValid;
  logic [NR-1:0] issueDest, issueSrcA, issueSrcB;
  logic          issueReady;
  logic [NF-1:0] issueGrant, doneVec, busy, goRead, goWrite;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  unary_scoreboard #(.NUM_FU(NF), .NUM_REG(NR)) u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueDest(issueDest),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueReady(issueReady),
    .issueGrant(issueGrant), .doneVec(doneVec), .busy(busy),
    .goRead(goRead), .goWrite(goWrite)
  );

  // behavioural reference state
  bit            mBusy [NF];
  logic [NR-1:0] mDst  [NF];
  logic [NR-1:0] mSrc  [NF];
  bit            mRw   [NF][NF];
  bit            mWw   [NF][NF];

  logic          lastReady;
  logic [NF-1:0] lastGrant;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NF-1:0] modelBusy();
    logic [NF-1:0] v = '0;
    for (int k = 0; k < NF; k++) v[k] = mBusy[k];
    return v;
  endfunction

  task automatic compareAll();
    logic          eReady;
    logic [NF-1:0] eGrant, eGoR, eGoW;
    logic [NR-1:0] pend;
    int            freeIdx;
    pend = '0;
    freeIdx = -1;
    for (int k = NF - 1; k >= 0; k--) begin
      if (mBusy[k]) pend |= mDst[k];
      else freeIdx = k;
    end
    eReady = (freeIdx >= 0) && ((issueDest & pend) == '0);
    eGrant = '0;
    if (issueValid && eReady) eGrant[freeIdx] = 1'b1;
    for (int k = 0; k < NF; k++) begin
      bit anyR = 0, anyW = 0;
      for (int m = 0; m < NF; m++) begin
        anyR |= mRw[k][m];
        anyW |= mWw[k][m];
      end
      eGoR[k] = mBusy[k] && !anyR;
      eGoW[k] = mBusy[k] && !anyW;
    end
    chk(issueReady === eReady, "R4 issueReady", 64'(issueReady), 64'(eReady));
    chk(issueGrant === eGrant, "R2 issueGrant", 64'(issueGrant), 64'(eGrant));
    chk(busy === modelBusy(), "R8 busy", 64'(busy), 64'(modelBusy()));
    chk(goRead === eGoR, "R5 goRead", 64'(goRead), 64'(eGoR));
    chk(goWrite === eGoW, "R6 goWrite", 64'(goWrite), 64'(eGoW));
    lastReady = issueReady;
    lastGrant = eGrant;
  endtask

  task automatic updateModel();
    bit            oldBusy [NF];
    logic [NR-1:0] srcAll;
    int            f;
    for (int k = 0; k < NF; k++) oldBusy[k] = mBusy[k];
    srcAll = issueSrcA | issueSrcB;
    f = -1;
    for (int k = NF - 1; k >= 0; k--) if (lastGrant[k]) f = k;
    if (f >= 0) begin
      for (int m = 0; m < NF; m++) begin
        mRw[f][m] = oldBusy[m] && ((srcAll & mDst[m]) != '0);
        mWw[f][m] = oldBusy[m] && ((issueDest & mSrc[m]) != '0);
      end
      mBusy[f] = 1;
      mDst[f]  = issueDest;
      mSrc[f]  = srcAll;
    end
    for (int k = 0; k < NF; k++) begin
      if (doneVec[k] && oldBusy[k]) begin
        mBusy[k] = 0;
        mDst[k]  = '0;
        mSrc[k]  = '0;
        for (int m = 0; m < NF; m++) begin
          mRw[k][m] = 0; mWw[k][m] = 0;
          mRw[m][k] = 0; mWw[m][k] = 0;
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic [NR-1:0] d, input logic [NR-1:0] a,
                      input logic [NR-1:0] b, input logic [NF-1:0] dn);
    issueValid = v; issueDest = d; issueSrcA = a; issueSrcB = b; doneVec = dn;
    #1;
    compareAll();
    @(posedge clk);
    updateModel();
    @(negedge clk);
  endtask

  function automatic logic [NR-1:0] reg1h(input int r);
    return NR'(1) << r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 0; issueValid = 0; issueDest = '0; issueSrcA = '0; issueSrcB = '0; doneVec = '0;
    for (int k = 0; k < NF; k++) begin
      mBusy[k] = 0; mDst[k] = '0; mSrc[k] = '0;
      for (int m = 0; m < NF; m++) begin mRw[k][m] = 0; mWw[k][m] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(busy === '0, "R1 busy", 64'(busy), 0);
    chk((goRead | goWrite) === '0, "R1 grants", 64'(goRead | goWrite), 0);
    chk(issueReady === 1'b1, "R1 issueReady", 64'(issueReady), 1);

    // RAW / WAR chain
    step(1, reg1h(5), reg1h(1), '0, '0);        // unit0 writes r5 reads r1
    chk(lastGrant === 8'h01, "R2 first grant", 64'(lastGrant), 1);
    step(1, reg1h(6), reg1h(5), '0, '0);        // unit1 reads r5
    chk(goRead[1] === 1'b0, "R5 read waits", 64'(goRead[1]), 0);
    chk(goWrite[1] === 1'b1, "R7 write free", 64'(goWrite[1]), 1);
    step(1, reg1h(1), '0, '0, '0);              // unit2 writes r1
    chk(goWrite[2] === 1'b0, "R6 write waits", 64'(goWrite[2]), 0);
    chk(goRead[2] === 1'b1, "R7 read free", 64'(goRead[2]), 1);
    step(1, reg1h(5), '0, '0, '0);              // WAW on r5
    chk(lastReady === 1'b0, "R4 waw stall", 64'(lastReady), 0);
    chk(busy === 8'h07, "R11 busy unchanged", 64'(busy), 7);
    step(0, '0, '0, '0, 8'h01);                 // unit0 completes
    chk(goRead[1] === 1'b1, "R8 RAW released", 64'(goRead[1]), 1);
    chk(goWrite[2] === 1'b1, "R8 WAR released", 64'(goWrite[2]), 1);
    step(1, reg1h(5), '0, '0, '0);
    chk(lastGrant === 8'h01, "R2 lowest idle reused", 64'(lastGrant), 1);
    step(0, '0, '0, '0, 8'hFF);
    chk(busy === '0, "R8 all freed", 64'(busy), 0);

    // done on idle unit
    step(1, reg1h(7), '0, '0, '0);
    step(0, '0, '0, '0, 8'h20);
    chk(busy === 8'h01, "R9 idle done ignored", 64'(busy), 1);
    chk(goWrite === 8'h01, "R9 grants kept", 64'(goWrite), 1);
    step(0, '0, '0, '0, 8'hFF);

    // fill the pool
    for (int k = 0; k < NF; k++) step(1, reg1h(10 + k), '0, '0, '0);
    step(1, reg1h(30), '0, '0, '0);
    chk(lastReady === 1'b0, "R3 full stall", 64'(lastReady), 0);
    step(0, '0, '0, '0, 8'hFF);

    // same-cycle completion and dependent issue
    step(1, reg1h(20), '0, '0, '0);
    step(1, reg1h(21), reg1h(20), '0, 8'h01);
    chk(goRead[1] === 1'b1, "R10 no stale wait", 64'(goRead[1]), 1);
    step(0, '0, '0, '0, 8'hFF);

    // random traffic over a few registers to provoke hazards
    for (int n = 0; n < 600; n++) begin
      logic [NR-1:0] d, a, b;
      d = ($urandom % 6 == 0) ? '0 : reg1h($urandom % 8);
      a = ($urandom % 3 == 0) ? '0 : reg1h($urandom % 8);
      b = ($urandom % 3 == 0) ? '0 : reg1h($urandom % 8);
      step($urandom % 4 != 0, d, a, b, NF'($urandom) & NF'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule